// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Control

This block is the hazard control for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle it receives the register tags of the instruction in decode. It keeps its own copy of the tags held in the three later pipeline registers. From these it drives the mux selects that route fresher results around the register file. Selects go to both ALU operand inputs, to the branch zero-test operand and to the store-data input of data memory. The register file, ALU and memories sit outside the block. Only their register numbers and enable bits reach it.

There are two possible bypass sources. One is the ALU result waiting in the memory stage. The other is the writeback value, which is an ALU result or a loaded word. Loaded data is not ready early enough to feed an instruction in execute. When a load in execute writes a register that the decode instruction needs, the block raises `stall` for one cycle. The pipeline then holds the PC and the fetch/decode register, and the block places an empty entry into execute.

A store may take its data register from a load immediately ahead of it without stalling. The loaded value reaches the store by a late bypass from writeback into the memory stage.

Top module: `bypass_interlock_ctrl`

## Requirements
- R1: After reset all three tracked stages are empty, so every select and `stall` read 0 for the first instruction presented.
- R2: The select codes are 0 for the register-file value, 1 for the memory-stage ALU result and 2 for the writeback value. An ALU or branch-test operand that is used gets select 1 when the memory-stage instruction writes that register and is not a load.
- R3: An operand that is used gets select 2 when only the writeback-stage instruction writes that register. This holds whether that value came from the ALU or from memory.
- R4: When the memory-stage and writeback-stage instructions both write the source register, select 1 is given, because it is the newer result.
- R5: Register 0 never produces a bypass or a stall. An instruction whose register-write enable is clear is never compared.
- R6: `st_data_fwd` is 1 when the store in the memory stage has a data register equal to the nonzero register written by the writeback-stage instruction.
- R7: The zero-test select follows R2 to R4 for the first source of a branch in execute, and is 0 whenever the execute instruction is not a branch.
- R8: `stall` is 1 when the execute-stage load writes a nonzero register that the decode instruction reads as its first source, or as its second source when it is not a store.
- R9: A store in decode that matches the execute-stage load only through its data register does not stall. Two cycles later, `st_data_fwd` is 1 for it.
- R10: The cycle after a stall, the execute entry is empty and `stall` is 0. The held instruction then re-enters, and when it reaches execute its dependent operand takes select 2.
- R11: A load in the memory stage is never chosen as select 1 for any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | Decode instruction first source register |
| id_rs2 | input | REG_W | Decode instruction second source (store data for stores) |
| id_rd | input | REG_W | Decode instruction destination register |
| id_rs1_used | input | 1 | First source is read |
| id_rs2_used | input | 1 | Second source is read |
| id_reg_we | input | 1 | Instruction writes a register |
| id_is_load | input | 1 | Instruction is a load |
| id_is_store | input | 1 | Instruction is a store |
| id_is_branch | input | 1 | Instruction is a zero-test branch |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| fwd_a_sel | output | 2 | ALU operand A source select |
| fwd_b_sel | output | 2 | ALU operand B source select |
| fwd_z_sel | output | 2 | Branch zero-test operand source select |
| st_data_fwd | output | 1 | Replace memory-stage store data with writeback value |

## Verification
The assertions check several rules on every cycle. A stall is always followed by an empty execute entry and never by a second stall. No operand ever takes the memory-stage result while that stage holds a load. Register 0 never produces a bypass. The zero-test select stays idle unless a branch is in execute. A store passed over by the interlock always receives the writeback bypass in the following cycle. Only the bench scenarios can show that each select carries the correct code for a given instruction sequence. They also show that the newer producer wins when two stages match, and that a held instruction returns with the right source once the stall clears.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Operand source select codes seen by the datapath muxes
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_EXMEM   = 2'd1,
    SRC_MEMWB   = 2'd2
  } fwd_src_e;

  localparam int unsigned NUM_OPERANDS = 3;  // ALU A, ALU B, zero-test

endpackage

// File: rtl/operand_src_sel.sv
module operand_src_sel
  import bypass_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_reg,
  input  logic             src_used,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_we,
  input  logic             exm_ld,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_we,
  output fwd_src_e         sel,
  output logic             hit_exm,
  output logic             hit_mwb
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A producer matches when it writes a real register equal to the source
  function automatic logic produces(input logic [REG_W-1:0] rd,
                                    input logic             we,
                                    input logic [REG_W-1:0] src);
    return we && (rd != ZERO_REG) && (rd == src);
  endfunction

  always_comb begin
    hit_exm = src_used && !exm_ld && produces(exm_rd, exm_we, src_reg);
    hit_mwb = src_used && produces(mwb_rd, mwb_we, src_reg);
    if (hit_exm)      sel = SRC_EXMEM;
    else if (hit_mwb) sel = SRC_MEMWB;
    else              sel = SRC_REGFILE;
  end

  always_comb begin
    // R5
    zero_src_chk: assert ((sel == SRC_REGFILE) || (src_reg != ZERO_REG));
    // R11
    load_not_bypassed_chk: assert (!(exm_ld && (sel == SRC_EXMEM)));
  end

endmodule

// File: rtl/store_data_bypass.sv
module store_data_bypass #(
  parameter int unsigned REG_W = 5
) (
  input  logic             exm_st,
  input  logic [REG_W-1:0] exm_rs2,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_we,
  output logic             st_fwd
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic logic data_hit(input logic [REG_W-1:0] rd,
                                    input logic             we,
                                    input logic [REG_W-1:0] data_reg);
    return we && (rd != ZERO_REG) && (rd == data_reg);
  endfunction

  always_comb st_fwd = exm_st && data_hit(mwb_rd, mwb_we, exm_rs2);

  always_comb begin
    // R6
    st_fwd_needs_store_chk: assert (!st_fwd || exm_st);
  end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int unsigned REG_W = 5
) (
  input  logic             idex_ld,
  input  logic             idex_we,
  input  logic [REG_W-1:0] idex_rd,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use1,
  input  logic             id_use2,
  input  logic             id_st,
  output logic             raw1,
  output logic             raw2,
  output logic             stall
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic logic load_feeds(input logic [REG_W-1:0] src,
                                      input logic             used);
    return used && idex_ld && idex_we && (idex_rd != ZERO_REG) && (idex_rd == src);
  endfunction

  always_comb begin
    raw1  = load_feeds(id_rs1, id_use1);
    raw2  = load_feeds(id_rs2, id_use2);
    // store data can be bypassed late, so it does not hold decode
    stall = raw1 || (raw2 && !id_st);
  end

  always_comb begin
    // R9
    store_data_exempt_chk: assert (!(id_st && raw2 && !raw1 && stall));
    // R8
    stall_needs_load_chk: assert (!stall || idex_ld);
  end

endmodule

// File: rtl/bypass_interlock_ctrl.sv
module bypass_interlock_ctrl
  import bypass_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_rs1_used,
  input  logic             id_rs2_used,
  input  logic             id_reg_we,
  input  logic             id_is_load,
  input  logic             id_is_store,
  input  logic             id_is_branch,
  output logic             stall,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic [1:0]       fwd_z_sel,
  output logic             st_data_fwd
);

  // Tag entry held between decode and execute
  typedef struct packed {
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             use1;
    logic             use2;
    logic             we;
    logic             ld;
    logic             st;
    logic             br;
  } ex_tag_t;

  // Tag entry held between execute and memory
  typedef struct packed {
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             we;
    logic             ld;
    logic             st;
  } mem_tag_t;

  // Tag entry held between memory and writeback
  typedef struct packed {
    logic [REG_W-1:0] rd;
    logic             we;
  } wb_tag_t;

  ex_tag_t  id_tag, idex_q;
  mem_tag_t exmem_q;
  wb_tag_t  memwb_q;

  logic     raw1, raw2;
  fwd_src_e op_sel [NUM_OPERANDS];
  logic     op_hit_exm [NUM_OPERANDS];
  logic     op_hit_mwb [NUM_OPERANDS];
  logic [REG_W-1:0] op_src  [NUM_OPERANDS];
  logic             op_used [NUM_OPERANDS];

  always_comb begin
    id_tag.rs1  = id_rs1;
    id_tag.rs2  = id_rs2;
    id_tag.rd   = id_rd;
    id_tag.use1 = id_rs1_used;
    id_tag.use2 = id_rs2_used;
    id_tag.we   = id_reg_we;
    id_tag.ld   = id_is_load;
    id_tag.st   = id_is_store;
    id_tag.br   = id_is_branch;
  end

  // Tag pipeline: a stall drops an empty entry into execute
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      idex_q      <= stall ? '0 : id_tag;
      exmem_q.rs2 <= idex_q.rs2;
      exmem_q.rd  <= idex_q.rd;
      exmem_q.we  <= idex_q.we;
      exmem_q.ld  <= idex_q.ld;
      exmem_q.st  <= idex_q.st;
      memwb_q.rd  <= exmem_q.rd;
      memwb_q.we  <= exmem_q.we;
    end
  end

  load_use_interlock #(.REG_W(REG_W)) u_interlock (
    .idex_ld (idex_q.ld),
    .idex_we (idex_q.we),
    .idex_rd (idex_q.rd),
    .id_rs1  (id_rs1),
    .id_rs2  (id_rs2),
    .id_use1 (id_rs1_used),
    .id_use2 (id_rs2_used),
    .id_st   (id_is_store),
    .raw1    (raw1),
    .raw2    (raw2),
    .stall   (stall)
  );

  // Operand channels: 0 = ALU A, 1 = ALU B, 2 = branch zero-test
  always_comb begin
    op_src[0]  = idex_q.rs1;
    op_used[0] = idex_q.use1;
    op_src[1]  = idex_q.rs2;
    op_used[1] = idex_q.use2;
    op_src[2]  = idex_q.rs1;
    op_used[2] = idex_q.use1 && idex_q.br;
  end

  for (genvar ch = 0; ch < NUM_OPERANDS; ch++) begin : g_operand
    operand_src_sel #(.REG_W(REG_W)) u_sel (
      .src_reg  (op_src[ch]),
      .src_used (op_used[ch]),
      .exm_rd   (exmem_q.rd),
      .exm_we   (exmem_q.we),
      .exm_ld   (exmem_q.ld),
      .mwb_rd   (memwb_q.rd),
      .mwb_we   (memwb_q.we),
      .sel      (op_sel[ch]),
      .hit_exm  (op_hit_exm[ch]),
      .hit_mwb  (op_hit_mwb[ch])
    );
  end

  store_data_bypass #(.REG_W(REG_W)) u_store_bypass (
    .exm_st  (exmem_q.st),
    .exm_rs2 (exmem_q.rs2),
    .mwb_rd  (memwb_q.rd),
    .mwb_we  (memwb_q.we),
    .st_fwd  (st_data_fwd)
  );

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];
  assign fwd_z_sel = op_sel[2];

  // R10
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (idex_q == '0));

  // R10
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R9
  store_late_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_q.st && exmem_q.ld && exmem_q.we && (exmem_q.rd != '0) &&
     (exmem_q.rd == idex_q.rs2)) |=> st_data_fwd);

  // R7
  zero_test_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_q.br |-> (fwd_z_sel == 2'd0));

  // R4
  newer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit_exm[0] && op_hit_mwb[0]) |-> (fwd_a_sel == 2'd1));

endmodule

// File: tb/bypass_interlock_ctrl_bench.sv
`timescale 1ns/1ps
module bypass_interlock_ctrl_bench;

  localparam int RW = 5;

  typedef struct {
    logic [RW-1:0] rs1, rs2, rd;
    bit u1, u2, we, ld, st, br;
  } ins_t;

  typedef struct {
    logic [1:0] a, b, z;
    bit st, stall;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] id_rs1, id_rs2, id_rd;
  logic id_rs1_used, id_rs2_used, id_reg_we, id_is_load, id_is_store, id_is_branch;
  logic stall, st_data_fwd;
  logic [1:0] fwd_a_sel, fwd_b_sel, fwd_z_sel;

  int checks = 0, failures = 0;
  exp_t sb_q[$];
  event sample_ev;
  ins_t m_ex, m_mem, m_wb, empty_ins;

  always #2 clk = ~clk;  // 250 MHz

  bypass_interlock_ctrl #(.REG_W(RW)) u_bypass_interlock_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .id_reg_we(id_reg_we), .id_is_load(id_is_load),
    .id_is_store(id_is_store), .id_is_branch(id_is_branch),
    .stall(stall), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .fwd_z_sel(fwd_z_sel), .st_data_fwd(st_data_fwd)
  );

  function automatic ins_t mk(int rd, int rs1, int rs2, bit u1, bit u2,
                              bit we, bit ld, bit st, bit br);
    ins_t i;
    i.rd = rd[RW-1:0]; i.rs1 = rs1[RW-1:0]; i.rs2 = rs2[RW-1:0];
    i.u1 = u1; i.u2 = u2; i.we = we; i.ld = ld; i.st = st; i.br = br;
    return i;
  endfunction
  function automatic ins_t alu(int rd, int a, int b); return mk(rd, a, b, 1, 1, 1, 0, 0, 0); endfunction
  function automatic ins_t lw(int rd, int base);      return mk(rd, base, 0, 1, 0, 1, 1, 0, 0); endfunction
  function automatic ins_t sw(int data, int base);    return mk(0, base, data, 1, 1, 0, 0, 1, 0); endfunction
  function automatic ins_t bz(int r);                 return mk(0, r, 0, 1, 0, 0, 0, 0, 1); endfunction
  function automatic ins_t nop();                     return mk(0, 0, 0, 0, 0, 0, 0, 0, 0); endfunction

  // Expected source per R2..R5, R11: newer non-load producer first, then writeback
  function automatic logic [1:0] want_src(logic [RW-1:0] r, bit used);
    if (!used || r == 0) return 2'd0;
    if (m_mem.we && !m_mem.ld && m_mem.rd == r) return 2'd1;
    if (m_wb.we && m_wb.rd == r) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit want_stall(ins_t d);
    bit hit1, hit2;
    if (!(m_ex.ld && m_ex.we && m_ex.rd != 0)) return 0;
    hit1 = d.u1 && d.rs1 == m_ex.rd;
    hit2 = d.u2 && d.rs2 == m_ex.rd;
    return hit1 || (hit2 && !d.st);
  endfunction

  task automatic drive(ins_t i);
    id_rs1 = i.rs1; id_rs2 = i.rs2; id_rd = i.rd;
    id_rs1_used = i.u1; id_rs2_used = i.u2; id_reg_we = i.we;
    id_is_load = i.ld; id_is_store = i.st; id_is_branch = i.br;
  endtask

  // Driver: present one instruction, repeating it while the interlock holds it
  task automatic issue(ins_t i, string tag);
    exp_t e;
    do begin
      @(negedge clk);
      drive(i);
      e.a = want_src(m_ex.rs1, m_ex.u1);
      e.b = want_src(m_ex.rs2, m_ex.u2);
      e.z = m_ex.br ? want_src(m_ex.rs1, m_ex.u1) : 2'd0;
      e.st = m_mem.st && m_wb.we && m_wb.rd != 0 && m_wb.rd == m_mem.rs2;
      e.stall = want_stall(i);
      e.tag = tag;
      sb_q.push_back(e);
      -> sample_ev;
      m_wb = m_mem; m_mem = m_ex;
      m_ex = e.stall ? empty_ins : i;
    end while (e.stall);
  endtask

  task automatic cmp(string what, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pop the expected item and compare against the outputs
  initial begin
    exp_t e;
    forever begin
      @(sample_ev);
      #1;
      e = sb_q.pop_front();
      cmp("fwd_a_sel", e.tag, fwd_a_sel, e.a);
      cmp("fwd_b_sel", e.tag, fwd_b_sel, e.b);
      cmp("fwd_z_sel", e.tag, fwd_z_sel, e.z);
      cmp("st_data_fwd", e.tag, st_data_fwd, e.st);
      cmp("stall", e.tag, stall, e.stall);
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    empty_ins = nop();
    m_ex = empty_ins; m_mem = empty_ins; m_wb = empty_ins;
    drive(nop());
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty stages after reset
    issue(alu(3, 1, 2), "R1");
    issue(alu(4, 5, 6), "R1");
    // R2: adjacent ALU dependence on both operands
    issue(alu(1, 7, 7), "R2");
    issue(alu(2, 1, 1), "R2");
    // R3: dependence with one instruction between
    issue(alu(8, 9, 9), "R3");
    issue(nop(), "R3");
    issue(alu(10, 11, 8), "R3");
    issue(nop(), "R3");
    // R4: two producers of the same register
    issue(alu(12, 0, 0), "R4");
    issue(alu(12, 0, 0), "R4");
    issue(alu(13, 12, 12), "R4");
    issue(nop(), "R4");
    // R5: register 0 and write-disabled instructions never match
    issue(alu(0, 1, 1), "R5");
    issue(alu(3, 0, 0), "R5");
    issue(mk(14, 0, 0, 0, 0, 0, 0, 0, 0), "R5");
    issue(alu(5, 14, 14), "R5");
    issue(lw(0, 1), "R5");
    issue(alu(6, 0, 0), "R5");
    issue(nop(), "R5");
    // R7: branch zero-test bypass and idle for non-branch
    issue(alu(15, 1, 2), "R7");
    issue(bz(15), "R7");
    issue(alu(16, 15, 15), "R7");
    issue(nop(), "R7");
    // R8, R10, R11: load-use stall then writeback bypass
    issue(lw(17, 1), "R8");
    issue(alu(18, 2, 17), "R10");
    issue(nop(), "R11");
    issue(lw(19, 2), "R8");
    issue(sw(3, 19), "R8");
    issue(nop(), "R10");
    issue(nop(), "R10");
    // R9, R6: store data taken from preceding load, no stall
    issue(lw(20, 1), "R9");
    issue(sw(20, 2), "R9");
    issue(nop(), "R6");
    issue(nop(), "R6");
    issue(alu(21, 1, 1), "R6");
    issue(nop(), "R6");
    issue(sw(21, 3), "R6");
    issue(nop(), "R6");
    issue(nop(), "R6");
    // Mixed stream over a small register set
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 5);
      int a = $urandom_range(0, 7), b = $urandom_range(0, 7), d = $urandom_range(0, 7);
      case (k)
        0, 1: issue(alu(d, a, b), "R2");
        2:    issue(lw(d, a), "R8");
        3:    issue(sw(b, a), "R9");
        4:    issue(bz(a), "R7");
        default: issue(nop(), "R3");
      endcase
    end
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule